// File: doc/BRIEF.md
# Bus-Written Prioritized Event Register

This block holds sixteen event-request flags that other bus masters raise and lower by writing into a small window of control space. Each level has its own word location. Only data bit 0 of a write matters: a 1 raises the flag and a 0 lowers it. The write may cover the whole word or only its lowest byte. Software that polls for work tests one pending output as a branch condition. It then reads the number of the most urgent pending level from a status word, services that level, and clears it by writing a 0 to the level's location.

Smaller level numbers are more urgent. The two most urgent levels, power failure (level 0) and boot request (level 1), are not meant to wait for polling. While either of them is raised, the block drives a separate abort output so that the processor traps at once. All outputs and read data are registered, so the port is suited to a single-clock bus fabric.

Top module: `evt_prio_reg`

## Requirements
- R1: Level L (0 to 15) owns the word at byte offset 4·L. A write to that offset with byte enable 0 set and data bit 0 equal to 1 raises flag L. The other data bits and the other byte enables have no effect.
- R2: A write to a level's offset with byte enable 0 set and data bit 0 equal to 0 lowers that flag. Other flags are unchanged.
- R3: Some writes leave every flag unchanged: a write with byte enable 0 clear, a write whose address bits [1:0] are not zero, a write to the status word at offset 0x40, and a write at or beyond offset 0x44.
- R4: A flag keeps its value until it is written again. A synchronous active-high reset lowers all flags and drives `evt_pending`, `evt_level`, `evt_abort` and `bus_rdata` to zero.
- R5: `evt_pending` is high one clock after the edge at which any flag is high, and low one clock after the edge at which no flag is high.
- R6: `evt_level` gives the lowest-numbered raised flag, one clock after the flags. It reads 0 when no flag is raised.
- R7: `evt_abort` is high one clock after flag 0 or flag 1 is raised. It is low one clock after both of them are low.
- R8: A read strobe loads `bus_rdata` at the clock edge. A level offset returns its flag in bit 0 and zeros in the other bits. Offset 0x40 returns the status word: bits [3:0] hold `evt_level`, bit 4 holds `evt_pending`, and the other bits are zero. Any other address returns zero. A read and a write in the same cycle return the value before the write. `bus_rdata` holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address within the window |
| bus_wdata | input | 32 | Write data; only bit 0 is used |
| bus_be | input | 4 | Byte enables; only bit 0 gates a write |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| evt_pending | output | 1 | Some level is raised |
| evt_level | output | 4 | Most urgent raised level |
| evt_abort | output | 1 | Level 0 or 1 is raised |

## Verification
A write takes effect on a flag at the edge where it is sampled. `evt_pending`, `evt_level` and `evt_abort` follow one edge after that, and read data appears at the edge where the read strobe is sampled. The bench's reference model mirrors these delays: it updates its own flag set at each rising edge and derives its expected outputs from the flag set as it stood before that edge. It compares every output at each falling edge, and the directed checks wait the same number of edges before they sample.

// File: rtl/evt_pkg.sv
package evt_pkg;

  // Kind of location an address selects inside the window.
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_FLAG = 2'd1,
    ACC_STAT = 2'd2
  } acc_kind_e;

endpackage

// File: rtl/evt_addr_decode.sv
module evt_addr_decode
  import evt_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_LEVELS = 16,
  localparam int IDX_W     = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);

  logic aligned;

  always_comb begin
    idx     = addr[ADDR_W-1:2];
    aligned = (addr[1:0] == 2'b00);
    if (!aligned)
      kind = ACC_NONE;
    else if (int'(idx) < NUM_LEVELS)
      kind = ACC_FLAG;
    else if (int'(idx) == NUM_LEVELS)
      kind = ACC_STAT;
    else
      kind = ACC_NONE;
  end

endmodule

// File: rtl/evt_flag_bank.sv
module evt_flag_bank
  import evt_pkg::*;
#(
  parameter int NUM_LEVELS = 16,
  parameter int IDX_W      = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  acc_kind_e             kind,
  input  logic [IDX_W-1:0]      idx,
  input  logic                  be0,
  input  logic                  d0,
  output logic [NUM_LEVELS-1:0] flags
);

  logic wr_ok;
  assign wr_ok = wr_en && be0 && (kind == ACC_FLAG);

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
    logic sel;
    assign sel = wr_ok && (idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst)
        flags[g] <= 1'b0;
      else if (sel)
        flags[g] <= d0;
    end

    // R1: an accepted write of 1 raises the flag
    assert_set_R1: assert property (@(posedge clk) disable iff (rst)
      (wr_en && be0 && kind == ACC_FLAG && idx == IDX_W'(g) && d0) |=> flags[g]);
    // R2: an accepted write of 0 lowers the flag
    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && be0 && kind == ACC_FLAG && idx == IDX_W'(g) && !d0) |=> !flags[g]);
  end

  // R3: a write that is not accepted leaves every flag alone
  assert_ignore_R3: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && be0 && kind == ACC_FLAG) |=> $stable(flags));

endmodule

// File: rtl/evt_prio_encoder.sv
module evt_prio_encoder #(
  parameter int NUM_LEVELS = 16,
  localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
  input  logic [NUM_LEVELS-1:0] flags,
  output logic                  any,
  output logic [LVL_W-1:0]      top
);

  // Scan from the least urgent level upward; the last hit is the lowest number.
  always_comb begin
    any = 1'b0;
    top = '0;
    for (int i = NUM_LEVELS - 1; i >= 0; i--) begin
      if (flags[i]) begin
        any = 1'b1;
        top = LVL_W'(i);
      end
    end
  end

endmodule

// File: rtl/evt_prio_reg.sv
module evt_prio_reg
  import evt_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int NUM_LEVELS = 16,
  parameter int NUM_ABORT  = 2,
  localparam int BE_W      = DATA_W / 8,
  localparam int IDX_W     = ADDR_W - 2,
  localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [BE_W-1:0]   bus_be,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              evt_pending,
  output logic [LVL_W-1:0]  evt_level,
  output logic              evt_abort
);

  acc_kind_e             kind;
  logic [IDX_W-1:0]      idx;
  logic [NUM_LEVELS-1:0] flags;
  logic                  any;
  logic [LVL_W-1:0]      top;
  logic [DATA_W-1:0]     rd_next;

  evt_addr_decode #(.ADDR_W(ADDR_W), .NUM_LEVELS(NUM_LEVELS)) u_dec (
    .addr (bus_addr),
    .kind (kind),
    .idx  (idx)
  );

  evt_flag_bank #(.NUM_LEVELS(NUM_LEVELS), .IDX_W(IDX_W)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .wr_en (bus_wr),
    .kind  (kind),
    .idx   (idx),
    .be0   (bus_be[0]),
    .d0    (bus_wdata[0]),
    .flags (flags)
  );

  evt_prio_encoder #(.NUM_LEVELS(NUM_LEVELS)) u_enc (
    .flags (flags),
    .any   (any),
    .top   (top)
  );

  always_comb begin
    rd_next = '0;
    case (kind)
      ACC_FLAG: rd_next[0] = flags[idx[LVL_W-1:0]];
      ACC_STAT: begin
        rd_next[LVL_W-1:0] = evt_level;
        rd_next[LVL_W]     = evt_pending;
      end
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_pending <= 1'b0;
      evt_level   <= '0;
      evt_abort   <= 1'b0;
      bus_rdata   <= '0;
    end else begin
      evt_pending <= any;
      evt_level   <= top;
      evt_abort   <= |flags[NUM_ABORT-1:0];
      if (bus_rd)
        bus_rdata <= rd_next;
    end
  end

  // R5: pending follows the flags one edge later
  assert_pend_hi_R5: assert property (@(posedge clk) disable iff (rst)
    (flags != '0) |=> evt_pending);
  assert_pend_lo_R5: assert property (@(posedge clk) disable iff (rst)
    (flags == '0) |=> !evt_pending);
  // R6: level zero stands when level 0 is raised, and when idle
  assert_lvl0_R6: assert property (@(posedge clk) disable iff (rst)
    flags[0] |=> (evt_level == '0));
  assert_idle_lvl_R6: assert property (@(posedge clk) disable iff (rst)
    !evt_pending |-> (evt_level == '0));
  // R7: abort follows the preemptive flags
  assert_abort_hi_R7: assert property (@(posedge clk) disable iff (rst)
    (|flags[NUM_ABORT-1:0]) |=> evt_abort);
  assert_abort_lo_R7: assert property (@(posedge clk) disable iff (rst)
    !(|flags[NUM_ABORT-1:0]) |=> !evt_abort);
  // R8: read data holds between reads
  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/sim_evt_prio_reg.sv
module sim_evt_prio_reg;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        evt_pending;
  logic [3:0]  evt_level;
  logic        evt_abort;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int cyc = 0;

  always #2 clk = ~clk;  // 250 MHz

  evt_prio_reg u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_be(bus_be), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .evt_pending(evt_pending), .evt_level(evt_level), .evt_abort(evt_abort)
  );

  // Behavioural reference model
  bit [15:0] m_flags;
  bit        m_pend, m_abort;
  bit [3:0]  m_lvl;
  bit [31:0] m_rdata;
  int        m_top, m_idx;
  bit        m_any, m_ab;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_flags = '0; m_pend = 0; m_abort = 0; m_lvl = '0; m_rdata = '0;
    end else begin
      m_any = (m_flags != 0);
      m_ab  = m_flags[0] | m_flags[1];
      m_top = 0;
      for (int i = 15; i >= 0; i--) if (m_flags[i]) m_top = i;
      m_idx = int'(bus_addr) / 4;
      if (bus_rd) begin
        if (bus_addr[1:0] != 2'b00) m_rdata = 0;
        else if (m_idx < 16)       m_rdata = {31'b0, m_flags[m_idx]};
        else if (m_idx == 16)      m_rdata = (32'(m_pend) << 4) | 32'(m_lvl);
        else                       m_rdata = 0;
      end
      if (bus_wr && bus_be[0] && bus_addr[1:0] == 2'b00 && m_idx < 16)
        m_flags[m_idx] = bus_wdata[0];
      m_pend  = m_any;
      m_lvl   = 4'(m_top);
      m_abort = m_ab;
    end
  end

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (cyc > 0 && !done) begin
      chk("R5", "evt_pending", int'(evt_pending), int'(m_pend));
      chk("R6", "evt_level",   int'(evt_level),   int'(m_lvl));
      chk("R7", "evt_abort",   int'(evt_abort),   int'(m_abort));
      chk("R8", "bus_rdata",   int'(bus_rdata),   int'(m_rdata));
    end
  end

  // Tasks are entered at a falling edge and leave at one.
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  logic [31:0] r;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R4: reset state
    chk("R4", "pending after reset", int'(evt_pending), 0);
    chk("R4", "rdata after reset", int'(bus_rdata), 0);

    // R1: full-word set of level 9, other bits noise
    wr(8'h24, 32'hFFFF_0001, 4'hF);
    rd(8'h24, r); chk("R1", "level 9 flag", int'(r), 1);
    chk("R6", "level with 9", int'(evt_level), 9);
    // R1: byte write sets level 3
    wr(8'h0C, 32'h0000_0001, 4'h1);
    settle(); chk("R6", "level with 3,9", int'(evt_level), 3);
    // R3: byte enable 0 clear does not clear
    wr(8'h0C, 32'h0, 4'hE);
    rd(8'h0C, r); chk("R3", "level 3 after be0=0", int'(r), 1);
    // R3: misaligned write ignored
    wr(8'h11, 32'h1, 4'hF);
    rd(8'h10, r); chk("R3", "level 4 after misaligned", int'(r), 0);
    // R3: status and out-of-window writes ignored
    wr(8'h40, 32'h1, 4'hF);
    wr(8'h44, 32'h1, 4'hF);
    rd(8'h40, r); chk("R8", "status word", int'(r), 32'h13);
    // R7: boot request raises abort
    wr(8'h04, 32'h1, 4'h1);
    settle(); chk("R7", "abort with level 1", int'(evt_abort), 1);
    chk("R6", "level with 1", int'(evt_level), 1);
    // R2: clear level 1
    wr(8'h04, 32'hFFFF_FFFE, 4'hF);
    settle(); chk("R2", "abort after clearing 1", int'(evt_abort), 0);
    // R7: power failure
    wr(8'h00, 32'h1, 4'h1);
    settle(); chk("R7", "abort with level 0", int'(evt_abort), 1);
    chk("R6", "level with 0", int'(evt_level), 0);
    rd(8'h40, r); chk("R8", "status with level 0", int'(r), 32'h10);
    // R8: read outside window
    rd(8'h48, r); chk("R8", "read outside", int'(r), 0);
    // R2: clear all
    wr(8'h00, 32'h0, 4'h1);
    wr(8'h0C, 32'h0, 4'h1);
    wr(8'h24, 32'h0, 4'h1);
    settle(); chk("R2", "pending after clear", int'(evt_pending), 0);
    chk("R6", "idle level", int'(evt_level), 0);
    // R4: flag persists over idle cycles
    wr(8'h3C, 32'h1, 4'h1);
    repeat (20) @(negedge clk);
    rd(8'h3C, r); chk("R4", "level 15 persists", int'(r), 1);

    // Random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      bus_addr  = 8'($urandom_range(0, 8'h4F));
      if ($urandom_range(0, 3) != 0) bus_addr[1:0] = 2'b00;
      bus_wdata = $urandom;
      bus_be    = 4'($urandom);
      bus_wr    = ($urandom_range(0, 2) == 0);
      bus_rd    = ($urandom_range(0, 1) == 0);
      @(negedge clk);
    end
    bus_wr = 1'b0; bus_rd = 1'b0;

    // R4: reset mid-run clears everything
    wr(8'h08, 32'h1, 4'h1);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    settle(); chk("R4", "pending after reset", int'(evt_pending), 0);
    rd(8'h08, r); chk("R4", "level 2 after reset", int'(r), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule